// File: doc/BRIEF.md
# In-Order Load Return Pipeline

This block sits behind the single load/store issue port of an integer core and hands load results back to the integer register file strictly in the order the loads were accepted. Each accepted request carries a tag, an access size, a signed/unsigned flag, a byte address, a hit/miss flag from the data-cache model and, on a hit, the 64-bit doubleword that holds the addressed bytes. The block chooses a return latency for each load, holds every load in an in-order return queue, merges refill data for misses, and drives one result per cycle onto a write-back port that has no stall.

Hits return after a fixed latency. The latency is longer for signed loads narrower than a doubleword, and that longer timing is passed on to any load accepted in the very next cycle. A miss stays in the queue until a refill pulse with its tag arrives, and every younger load waits behind it. A load whose address does not match its size returns a trap flag in its own slot in the order, with no data. The request side uses valid/ready: a request is taken in a cycle where both `req_valid` and `req_ready` are high, and `req_ready` is low only while the queue holds `DEPTH` entries. The return side is valid-only, because the register file accepts a write in every cycle. Refill is a one-cycle pulse.

Top module: `ldret_pipe`

## Requirements
- R1: A load that is not a signed narrow load, and that is accepted in a cycle not directly after a slow-timed accept, has return latency 2. If accepted in cycle c and nothing older is pending, `rsp_valid` is high with its tag in cycle c+2.
- R2: A signed load of size byte (`req_size`=0), halfword (1) or word (2) has return latency 3. A doubleword (3) uses latency 2.
- R3: A load accepted in the cycle directly after an accepted slow-timed load is also slow-timed (latency 3). The chain breaks after the first cycle with no accept.
- R4: Results leave in accept order. A younger load, hit or trap, never returns before an older load that is still waiting for refill.
- R5: A miss completes when `refill_valid` is high with `refill_tag` equal to its tag. If it is at the head, it returns in the next cycle with data taken from `refill_line`. A refill with any other tag has no effect.
- R6: Misalignment is judged on the size: halfword needs `addr[0]`=0, word needs `addr[1:0]`=0, doubleword needs `addr[2:0]`=0, and a byte is never misaligned. A misaligned load returns with `rsp_trap`=1 and `rsp_data`=0. It keeps its place in the order and uses the latency that R1 to R3 give it.
- R7: Data is taken from the 64-bit line with byte 0 in bits 7:0, starting at byte offset `addr[2:0]`. It is zero-extended when unsigned and sign-extended when signed.
- R8: At most one result per cycle. `req_ready` is low exactly while `DEPTH` (8) loads are held, and a request presented while it is low is not taken.
- R9: After reset, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Queue can take a request this cycle |
| req_tag | input | TAG_W | Destination tag of the load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| req_signed | input | 1 | Sign-extend the result |
| req_addr | input | ADDR_W | Byte address |
| req_hit | input | 1 | Cache model reports a hit |
| req_line | input | 64 | Doubleword holding the data, used on a hit |
| refill_valid | input | 1 | Refill pulse |
| refill_tag | input | TAG_W | Tag of the miss being refilled |
| refill_line | input | 64 | Refill doubleword |
| rsp_valid | output | 1 | Result on the write-back port |
| rsp_tag | output | TAG_W | Tag of the result |
| rsp_data | output | 64 | Extended load data, zero on trap |
| rsp_trap | output | 1 | Result is a misalignment trap |

## Verification
A wrong latency counter or a wrong latency choice shows up as a result that arrives one cycle early or late. The bench measures this against the accept cycle, to the exact cycle. A lost or stuck miss-completion bit shows up either as younger results leaving before a miss or as the port stalling forever after a refill. Both are caught within a few cycles of the refill, because each result is matched against an in-order scoreboard. A wrong occupancy count shows as `req_ready` being wrong on the cycle after the eighth accept, or as an extra or missing result once the queue drains.

// File: rtl/ldret_pkg.sv
package ldret_pkg;

  localparam int LINE_W = 64;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } ld_size_e;

  // true when the low address bits do not suit the access size
  function automatic logic size_misaligned(input ld_size_e sz, input logic [2:0] off);
    case (sz)
      SZ_HALF: return off[0];
      SZ_WORD: return |off[1:0];
      SZ_DBL:  return |off;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ldret_classify.sv
module ldret_classify
  import ldret_pkg::*;
#(
  parameter int FAST_LAT = 2,
  parameter int SLOW_LAT = 3,
  parameter int LAT_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [1:0]       size,
  input  logic             is_signed,
  input  logic [2:0]       off,
  output logic             slow,
  output logic             trap,
  output logic [LAT_W-1:0] wait_init
);

  logic chain_q;
  logic narrow_signed;

  assign narrow_signed = is_signed && (ld_size_e'(size) != SZ_DBL);
  assign slow          = narrow_signed || chain_q;
  assign trap          = size_misaligned(ld_size_e'(size), off);
  assign wait_init     = slow ? LAT_W'(SLOW_LAT - 1) : LAT_W'(FAST_LAT - 1);

  // delayed timing propagates only into the directly following accept
  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= 1'b0;
    else        chain_q <= accept && slow;
  end

endmodule

// File: rtl/ldret_queue.sv
module ldret_queue
  import ldret_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = 4,
  parameter int LAT_W = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [TAG_W-1:0]             push_tag,
  input  logic [1:0]                   push_size,
  input  logic                         push_sgn,
  input  logic [2:0]                   push_off,
  input  logic                         push_hit,
  input  logic                         push_trap,
  input  logic [LAT_W-1:0]             push_wait,
  input  logic [LINE_W-1:0]            push_line,
  input  logic                         refill_valid,
  input  logic [TAG_W-1:0]             refill_tag,
  input  logic [LINE_W-1:0]            refill_line,
  input  logic                         pop,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   occ,
  output logic                         head_rdy,
  output logic [TAG_W-1:0]             head_tag,
  output logic [1:0]                   head_size,
  output logic                         head_sgn,
  output logic [2:0]                   head_off,
  output logic                         head_trap,
  output logic [LINE_W-1:0]            head_line
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [1:0]       size;
    logic             sgn;
    logic [2:0]       off;
    logic             trap;
  } meta_t;

  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] occ_q;

  logic              vld_a  [DEPTH];
  logic              done_a [DEPTH];
  logic [LAT_W-1:0]  wait_a [DEPTH];
  meta_t             meta_a [DEPTH];
  logic [LINE_W-1:0] line_a [DEPTH];

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic              vld_r, done_r;
    logic [LAT_W-1:0]  wait_r;
    meta_t             meta_r;
    logic [LINE_W-1:0] line_r;
    logic              wr_en, rd_en, fill_hit;

    assign wr_en    = push && (wr_ptr == PTR_W'(i));
    assign rd_en    = pop  && (rd_ptr == PTR_W'(i));
    assign fill_hit = vld_r && !done_r && refill_valid && (refill_tag == meta_r.tag);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_r  <= 1'b0;
        done_r <= 1'b0;
        wait_r <= '0;
        meta_r <= '0;
        line_r <= '0;
      end else if (wr_en) begin
        vld_r  <= 1'b1;
        done_r <= push_hit || push_trap;
        wait_r <= push_wait;
        meta_r <= '{tag: push_tag, size: push_size, sgn: push_sgn,
                    off: push_off, trap: push_trap};
        line_r <= push_trap ? '0 : push_line;
      end else begin
        if (rd_en) vld_r <= 1'b0;
        if (vld_r && (wait_r != '0)) wait_r <= wait_r - 1'b1;
        if (fill_hit) begin
          done_r <= 1'b1;
          line_r <= refill_line;
        end
      end
    end

    assign vld_a[i]  = vld_r;
    assign done_a[i] = done_r;
    assign wait_a[i] = wait_r;
    assign meta_a[i] = meta_r;
    assign line_a[i] = line_r;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ_q  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({push, pop})
        2'b10:   occ_q <= occ_q + 1'b1;
        2'b01:   occ_q <= occ_q - 1'b1;
        default: occ_q <= occ_q;
      endcase
    end
  end

  assign occ       = occ_q;
  assign full      = (occ_q == CNT_W'(DEPTH));
  assign head_rdy  = vld_a[rd_ptr] && done_a[rd_ptr] && (wait_a[rd_ptr] == '0);
  assign head_tag  = meta_a[rd_ptr].tag;
  assign head_size = meta_a[rd_ptr].size;
  assign head_sgn  = meta_a[rd_ptr].sgn;
  assign head_off  = meta_a[rd_ptr].off;
  assign head_trap = meta_a[rd_ptr].trap;
  assign head_line = line_a[rd_ptr];

endmodule

// File: rtl/ldret_extend.sv
module ldret_extend
  import ldret_pkg::*;
(
  input  logic [LINE_W-1:0] line,
  input  logic [2:0]        off,
  input  logic [1:0]        size,
  input  logic              sgn,
  input  logic              trap,
  output logic [LINE_W-1:0] data
);

  logic [LINE_W-1:0] lane;
  logic [LINE_W-1:0] ext;

  always_comb begin
    lane = line >> {off, 3'b000};
    case (ld_size_e'(size))
      SZ_BYTE: ext = {{56{sgn & lane[7]}},  lane[7:0]};
      SZ_HALF: ext = {{48{sgn & lane[15]}}, lane[15:0]};
      SZ_WORD: ext = {{32{sgn & lane[31]}}, lane[31:0]};
      default: ext = lane;
    endcase
    data = trap ? '0 : ext;
  end

endmodule

// File: rtl/ldret_pipe.sv
module ldret_pipe
  import ldret_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int TAG_W    = 4,
  parameter int ADDR_W   = 16,
  parameter int FAST_LAT = 2,
  parameter int SLOW_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_hit,
  input  logic [63:0]       req_line,
  input  logic              refill_valid,
  input  logic [TAG_W-1:0]  refill_tag,
  input  logic [63:0]       refill_line,
  output logic              rsp_valid,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [63:0]       rsp_data,
  output logic              rsp_trap
);

  localparam int LAT_W = (SLOW_LAT > 2) ? $clog2(SLOW_LAT) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              accept, full;
  logic              cls_slow, cls_trap;
  logic [LAT_W-1:0]  cls_wait;
  logic [CNT_W-1:0]  occ;
  logic              head_rdy, head_sgn, head_trap;
  logic [TAG_W-1:0]  head_tag;
  logic [1:0]        head_size;
  logic [2:0]        head_off;
  logic [LINE_W-1:0] head_line;
  logic              addr_unused;

  assign addr_unused = ^req_addr[ADDR_W-1:3];
  assign req_ready   = !full;
  assign accept      = req_valid && req_ready;

  ldret_classify #(
    .FAST_LAT (FAST_LAT),
    .SLOW_LAT (SLOW_LAT),
    .LAT_W    (LAT_W)
  ) u_cls (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .size      (req_size),
    .is_signed (req_signed),
    .off       (req_addr[2:0]),
    .slow      (cls_slow),
    .trap      (cls_trap),
    .wait_init (cls_wait)
  );

  ldret_queue #(
    .DEPTH (DEPTH),
    .TAG_W (TAG_W),
    .LAT_W (LAT_W)
  ) u_q (
    .clk          (clk),
    .rst_n        (rst_n),
    .push         (accept),
    .push_tag     (req_tag),
    .push_size    (req_size),
    .push_sgn     (req_signed),
    .push_off     (req_addr[2:0]),
    .push_hit     (req_hit),
    .push_trap    (cls_trap),
    .push_wait    (cls_wait),
    .push_line    (req_line),
    .refill_valid (refill_valid),
    .refill_tag   (refill_tag),
    .refill_line  (refill_line),
    .pop          (head_rdy),
    .full         (full),
    .occ          (occ),
    .head_rdy     (head_rdy),
    .head_tag     (head_tag),
    .head_size    (head_size),
    .head_sgn     (head_sgn),
    .head_off     (head_off),
    .head_trap    (head_trap),
    .head_line    (head_line)
  );

  ldret_extend u_ext (
    .line (head_line),
    .off  (head_off),
    .size (head_size),
    .sgn  (head_sgn),
    .trap (head_trap),
    .data (rsp_data)
  );

  assign rsp_valid = head_rdy;
  assign rsp_tag   = head_tag;
  assign rsp_trap  = head_rdy && head_trap;

endmodule

// File: rtl/ldret_pipe_chk.sv
module ldret_pipe_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [1:0]       req_size,
  input logic             req_signed,
  input logic             rsp_valid,
  input logic             rsp_trap,
  input logic [63:0]      rsp_data,
  input logic [CNT_W-1:0] occ,
  input logic             cls_slow
);

  logic acc;
  logic seen_q;

  assign acc = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  // R6
  trap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_trap |-> rsp_data == 64'd0);

  // R2
  signed_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_signed && (req_size != 2'd3) |-> cls_slow);

  // R3
  chain_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && acc && $past(acc && cls_slow) |-> cls_slow);

  // R1
  fast_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && acc && !(req_signed && (req_size != 2'd3)) && !$past(acc && cls_slow) |-> !cls_slow);

  // R8
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH));

  // R8
  occ_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> (occ == $past(occ)) || (occ == $past(occ) + 1'b1) || (occ + 1'b1 == $past(occ)));

  // R8
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> occ != '0);

  // R8
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CNT_W'(DEPTH)) && !rsp_valid |=> occ == CNT_W'(DEPTH));

endmodule

bind ldret_pipe ldret_pipe_chk #(
  .DEPTH (DEPTH),
  .CNT_W (CNT_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_size   (req_size),
  .req_signed (req_signed),
  .rsp_valid  (rsp_valid),
  .rsp_trap   (rsp_trap),
  .rsp_data   (rsp_data),
  .occ        (occ),
  .cls_slow   (cls_slow)
);

// File: tb/ldret_pipe_tb_top.sv
module ldret_pipe_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_tag = '0;
  logic [1:0]  req_size = '0;
  logic        req_signed = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_hit = 1'b0;
  logic [63:0] req_line = '0;
  logic        refill_valid = 1'b0;
  logic [3:0]  refill_tag = '0;
  logic [63:0] refill_line = '0;
  logic        rsp_valid;
  logic [3:0]  rsp_tag;
  logic [63:0] rsp_data;
  logic        rsp_trap;

  always #10 clk = ~clk;

  ldret_pipe dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_tag(req_tag), .req_size(req_size), .req_signed(req_signed),
    .req_addr(req_addr), .req_hit(req_hit), .req_line(req_line),
    .refill_valid(refill_valid), .refill_tag(refill_tag), .refill_line(refill_line),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data), .rsp_trap(rsp_trap)
  );

  typedef struct {
    logic [3:0]  tag;
    logic [63:0] data;
    logic        trap;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  exp_t mon_e;
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  int   ret_cyc[16];
  int   iss_cyc[16];
  bit   prev_slow = 0;
  int   prev_cyc = -10;
  int   rf_cyc;
  bit   finished = 0;

  always @(posedge clk) cyc = cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_data(input logic [63:0] line, input logic [2:0] off,
                                          input logic [1:0] sz, input logic sg);
    logic [63:0] s;
    s = line >> (int'(off) * 8);
    case (sz)
      2'd0: return sg ? {{56{s[7]}},  s[7:0]}  : {56'd0, s[7:0]};
      2'd1: return sg ? {{48{s[15]}}, s[15:0]} : {48'd0, s[15:0]};
      2'd2: return sg ? {{32{s[31]}}, s[31:0]} : {32'd0, s[31:0]};
      default: return s;
    endcase
  endfunction

  function automatic logic is_mis(input logic [1:0] sz, input logic [2:0] off);
    return (sz == 2'd1 && off[0]) || (sz == 2'd2 && off[1:0] != 0) || (sz == 2'd3 && off != 0);
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R4", "unexpected result tag", rsp_tag, 0);
      end else begin
        mon_e = exp_q.pop_front();
        chk(rsp_tag == mon_e.tag, "R4", "order tag", rsp_tag, mon_e.tag);
        chk(rsp_trap == mon_e.trap, "R6", "trap flag", rsp_trap, mon_e.trap);
        chk(rsp_data == mon_e.data, mon_e.req, "data", rsp_data, mon_e.data);
      end
      ret_cyc[rsp_tag] = cyc;
    end
  end

  task automatic clear_ret();
    for (int i = 0; i < 16; i++) ret_cyc[i] = -1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: called at a falling edge, leaves at the next falling edge
  task automatic issue(input logic [3:0] tag, input logic [1:0] sz, input logic sg,
                       input logic [15:0] addr, input logic hit, input logic [63:0] line);
    exp_t e;
    bit   mis;
    bit   slow;
    mis  = is_mis(sz, addr[2:0]);
    slow = (sg && sz != 2'd3) || (prev_slow && prev_cyc == cyc - 1);
    chk(req_ready == 1'b1, "R8", "ready before issue", req_ready, 1);
    req_valid  = 1'b1;
    req_tag    = tag;
    req_size   = sz;
    req_signed = sg;
    req_addr   = addr;
    req_hit    = hit;
    req_line   = hit ? line : ~line;
    e.tag  = tag;
    e.trap = mis;
    e.data = mis ? 64'd0 : exp_data(line, addr[2:0], sz, sg);
    e.req  = mis ? "R6" : "R7";
    exp_q.push_back(e);
    iss_cyc[tag] = cyc;
    prev_slow = slow;
    prev_cyc  = cyc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic refill(input logic [3:0] tag, input logic [63:0] line);
    refill_valid = 1'b1;
    refill_tag   = tag;
    refill_line  = line;
    rf_cyc = cyc;
    @(negedge clk);
    refill_valid = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  localparam logic [63:0] LA = 64'h8899_AABB_CCDD_EEFF;
  localparam logic [63:0] LB = 64'h80F0_7FFF_FFFF_9C11;
  localparam logic [63:0] LC = 64'h0123_4567_89AB_CDEF;

  initial begin
    int s;
    clear_ret();
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R9 reset state
    chk(rsp_valid == 1'b0, "R9", "rsp_valid after reset", rsp_valid, 0);
    chk(req_ready == 1'b1, "R9", "req_ready after reset", req_ready, 1);

    // R1 fast hits
    issue(4'd1, 2'd2, 1'b0, 16'h0104, 1'b1, LA); idle(4);
    chk(ret_cyc[1] == iss_cyc[1] + 2, "R1", "unsigned word latency", ret_cyc[1] - iss_cyc[1], 2);
    issue(4'd2, 2'd3, 1'b1, 16'h0208, 1'b1, LB); idle(4);
    chk(ret_cyc[2] == iss_cyc[2] + 2, "R1", "signed dword latency", ret_cyc[2] - iss_cyc[2], 2);

    // R2 signed narrow hits
    issue(4'd3, 2'd0, 1'b1, 16'h0301, 1'b1, LB); idle(5);
    chk(ret_cyc[3] == iss_cyc[3] + 3, "R2", "signed byte latency", ret_cyc[3] - iss_cyc[3], 3);
    issue(4'd4, 2'd1, 1'b1, 16'h0306, 1'b1, LB); idle(5);
    chk(ret_cyc[4] == iss_cyc[4] + 3, "R2", "signed half latency", ret_cyc[4] - iss_cyc[4], 3);

    // R3 chained delayed timing
    clear_ret();
    issue(4'd5, 2'd1, 1'b1, 16'h0402, 1'b1, LC);
    issue(4'd6, 2'd2, 1'b0, 16'h0400, 1'b1, LC);
    issue(4'd7, 2'd0, 1'b0, 16'h0403, 1'b1, LC);
    idle(1);
    issue(4'd8, 2'd2, 1'b0, 16'h0404, 1'b1, LC);
    idle(6);
    chk(ret_cyc[5] == iss_cyc[5] + 3, "R3", "chain head latency", ret_cyc[5] - iss_cyc[5], 3);
    chk(ret_cyc[6] == iss_cyc[6] + 3, "R3", "chained word latency", ret_cyc[6] - iss_cyc[6], 3);
    chk(ret_cyc[7] == iss_cyc[7] + 3, "R3", "chained byte latency", ret_cyc[7] - iss_cyc[7], 3);
    chk(ret_cyc[8] == iss_cyc[8] + 2, "R3", "chain broken latency", ret_cyc[8] - iss_cyc[8], 2);

    // R4 / R5 miss holds younger hits
    clear_ret();
    issue(4'd10, 2'd3, 1'b0, 16'h0500, 1'b0, LC);
    issue(4'd11, 2'd2, 1'b0, 16'h0504, 1'b1, LA);
    issue(4'd12, 2'd0, 1'b1, 16'h0507, 1'b1, LB);
    idle(8);
    chk(ret_cyc[11] == -1, "R4", "hit passed older miss", ret_cyc[11], -1);
    chk(ret_cyc[12] == -1, "R4", "hit passed older miss", ret_cyc[12], -1);
    refill(4'd13, LA); idle(4);
    chk(ret_cyc[10] == -1, "R5", "wrong-tag refill completed miss", ret_cyc[10], -1);
    refill(4'd10, LC); idle(6);
    chk(ret_cyc[10] == rf_cyc + 1, "R5", "miss return cycle", ret_cyc[10] - rf_cyc, 1);
    chk(ret_cyc[11] == rf_cyc + 2, "R4", "held hit return cycle", ret_cyc[11] - rf_cyc, 2);
    chk(ret_cyc[12] == rf_cyc + 3, "R4", "held hit return cycle", ret_cyc[12] - rf_cyc, 3);

    // R6 misaligned
    clear_ret();
    issue(4'd1, 2'd1, 1'b0, 16'h0601, 1'b1, LA); idle(5);
    chk(ret_cyc[1] == iss_cyc[1] + 2, "R6", "trap latency", ret_cyc[1] - iss_cyc[1], 2);
    issue(4'd2, 2'd2, 1'b1, 16'h0602, 1'b1, LA); idle(5);
    chk(ret_cyc[2] == iss_cyc[2] + 3, "R6", "signed word trap latency", ret_cyc[2] - iss_cyc[2], 3);
    issue(4'd3, 2'd3, 1'b0, 16'h0604, 1'b1, LA);
    issue(4'd4, 2'd0, 1'b1, 16'h0607, 1'b1, LA); idle(5);
    issue(4'd5, 2'd2, 1'b0, 16'h0610, 1'b0, LB);
    issue(4'd6, 2'd1, 1'b0, 16'h0613, 1'b1, LB);
    idle(6);
    chk(ret_cyc[6] == -1, "R6", "trap passed older miss", ret_cyc[6], -1);
    refill(4'd5, LB); idle(5);
    chk(ret_cyc[6] == rf_cyc + 2, "R6", "trap kept order", ret_cyc[6] - rf_cyc, 2);

    // R7 lane select and extension
    issue(4'd1, 2'd0, 1'b1, 16'h0707, 1'b1, LB);
    issue(4'd2, 2'd1, 1'b0, 16'h0702, 1'b1, LB);
    issue(4'd3, 2'd2, 1'b1, 16'h0704, 1'b1, LB);
    issue(4'd4, 2'd0, 1'b1, 16'h0700, 1'b1, LB);
    issue(4'd5, 2'd2, 1'b1, 16'h0700, 1'b1, LC);
    idle(8);

    // R8 full queue back-pressure
    clear_ret();
    for (int t = 0; t < 8; t++) issue(4'(t), 2'd3, 1'b0, 16'h0800, 1'b0, LA ^ 64'(t));
    chk(req_ready == 1'b0, "R8", "ready when full", req_ready, 0);
    req_valid = 1'b1; req_tag = 4'd9; req_size = 2'd0; req_signed = 1'b0;
    req_addr = 16'h0900; req_hit = 1'b1; req_line = LC;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(req_ready == 1'b0, "R8", "ready while held full", req_ready, 0);
    end
    req_valid = 1'b0;
    s = cyc;
    for (int t = 7; t >= 0; t--) refill(4'(t), LA ^ 64'(t));
    idle(12);
    chk(ret_cyc[0] == s + 8, "R8", "first drain cycle", ret_cyc[0] - s, 8);
    chk(ret_cyc[7] == s + 15, "R8", "one per cycle drain", ret_cyc[7] - s, 15);
    chk(ret_cyc[9] == -1, "R8", "request taken while not ready", ret_cyc[9], -1);
    chk(req_ready == 1'b1, "R8", "ready after drain", req_ready, 1);
    chk(exp_q.size() == 0, "R4", "results outstanding", exp_q.size(), 0);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end

endmodule